// File: doc/BRIEF.md
# Humidity Sensor I2C Polling Sequencer

This block is a single-purpose I2C master that takes one reading from a combined humidity and temperature sensor each time it is triggered. A trigger starts a short write transaction that tells the sensor to begin a conversion. The block then waits out a fixed conversion time, opens a read transaction, and collects four raw bytes. These bytes appear as one 32-bit word, together with a one-cycle valid strobe. The write-wait-read order is fixed and always runs in full, because a read that does not follow a fresh trigger and wait only returns the previous conversion.

Both bus lines are open-drain. The block never drives them high: it asserts a drive-low output or releases the line, and external pull-ups do the rest. The SDA line level is sampled back through a separate input. Bit timing comes from a quarter-period divider parameter. The conversion wait is counted in system clocks, derived from the clock frequency parameter and a millisecond parameter, so a bench can scale it down. A NACK from the sensor during the trigger write ends the cycle with a STOP and raises a sticky error flag.

Top module: `hsense_poller`

## Requirements
- R1: After reset, and whenever the sequencer is idle, both drive-low outputs are 0 (lines released), `result_valid_o` is 0 and, after reset, `result_o` is 0 and `nack_err_o` is 0.
- R2: A pulse on `start_i` while idle produces a START, then the address byte 0x50 (7-bit address 0x28, R/W bit 0 = write), then exactly one trigger byte (value `TRIG_BYTE`, default 0x00, whose content the sensor ignores), then a STOP.
- R3: Between the STOP of the trigger write and the START of the read, at least `CLK_HZ/1000*CONV_MS` system clocks elapse.
- R4: Every measurement contains both transactions. The read is a START, the address byte 0x51 (R/W bit 1 = read), exactly four data bytes and a STOP.
- R5: The master acknowledges data bytes 1, 2 and 3 by holding SDA low in the ninth clock, and releases SDA (NACK) in the ninth clock after byte 4.
- R6: `result_o` becomes {byte1, byte2, byte3, byte4}, each byte taken MSB first, with the first byte received in bits [31:24]. It updates in the single cycle in which `result_valid_o` is high and holds its value at all other times.
- R7: If the sensor NACKs the address byte or the trigger byte, the block sends a STOP, sets `nack_err_o`, never raises `result_valid_o`, issues no read transaction and keeps `result_o` unchanged.
- R8: `nack_err_o` stays set until the next accepted `start_i`, which clears it in the following cycle.
- R9: Outside START and STOP conditions, the SDA drive changes only while SCL is driven low, so the bus shows exactly one START and one STOP per transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Trigger pulse; begins one measurement when idle |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| result_o | output | 32 | Four raw sensor bytes, first byte in the top bits |
| result_valid_o | output | 1 | One-cycle strobe when `result_o` updates |
| nack_err_o | output | 1 | Sticky flag: the sensor refused the address or trigger byte |

## Verification
The bench attaches a behavioural sensor model to the wired-AND bus and targets these corner cases:
- Byte packing, checked with patterns whose bytes differ. A design that reversed the byte order or the bit order would return a scrambled word.
- The ninth-clock acknowledge pattern. A master that ACKed the fourth byte, or NACKed an earlier one, would show up in the logged acknowledge bits.
- A shortened conversion gap, caught by timestamping the trigger STOP and the read START.
- NACK on the address and NACK on the trigger byte. A design that carried on into the read, pulsed valid or overwrote the result would be caught. So would one that dropped the error flag early or failed to clear it on the next trigger.
- Spurious START or STOP conditions from SDA moving while SCL is high, which would appear as extra bus events.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

    typedef enum logic [1:0] {
        BC_START = 2'd0,
        BC_STOP  = 2'd1,
        BC_WRITE = 2'd2,
        BC_READ  = 2'd3
    } bitcmd_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_START = 3'd1,
        S_TXBIT = 3'd2,
        S_TXACK = 3'd3,
        S_RXBIT = 3'd4,
        S_RXACK = 3'd5,
        S_STOP  = 3'd6,
        S_WAIT  = 3'd7
    } seq_state_e;

endpackage

// File: rtl/hsp_bit_engine.sv
module hsp_bit_engine
    import hsp_pkg::*;
#(
    parameter int SCL_QTR = 250
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cmd_valid_i,
    input  bitcmd_e cmd_i,
    input  logic    cmd_bit_i,
    input  logic    sda_i,
    output logic    done_o,
    output logic    rbit_o,
    output logic    scl_low_o,
    output logic    sda_low_o
);

    localparam int QW = (SCL_QTR > 1) ? $clog2(SCL_QTR) : 1;
    localparam logic [QW-1:0] Q_LAST = QW'(SCL_QTR - 1);

    typedef struct packed {
        logic          busy;
        bitcmd_e       cmd;
        logic          wbit;
        logic [1:0]    phase;
        logic [QW-1:0] cnt;
        logic          scl_low;
        logic          sda_low;
        logic          rbit;
        logic          done;
    } eng_t;

    eng_t q, d;

    // Returns {scl_low, sda_low} for one quarter of a bit slot.
    function automatic logic [1:0] phase_drive(bitcmd_e c, logic [1:0] ph, logic b);
        logic scl_dn;
        scl_dn = (ph == 2'd0) || (ph == 2'd3);
        case (c)
            BC_START: phase_drive = (ph == 2'd3) ? 2'b11 : ((ph == 2'd2) ? 2'b01 : 2'b00);
            BC_STOP:  phase_drive = (ph == 2'd0) ? 2'b11 : ((ph == 2'd1) ? 2'b01 : 2'b00);
            BC_WRITE: phase_drive = {scl_dn, ~b};
            default:  phase_drive = {scl_dn, 1'b0};
        endcase
    endfunction

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (cmd_valid_i) begin
                d.busy  = 1'b1;
                d.cmd   = cmd_i;
                d.wbit  = cmd_bit_i;
                d.phase = 2'd0;
                d.cnt   = '0;
                {d.scl_low, d.sda_low} = phase_drive(cmd_i, 2'd0, cmd_bit_i);
            end
        end else begin
            if (q.phase == 2'd1 && q.cnt == Q_LAST) begin
                d.rbit = sda_i;
            end
            if (q.cnt == Q_LAST) begin
                d.cnt = '0;
                if (q.phase == 2'd3) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.phase = q.phase + 2'd1;
                    {d.scl_low, d.sda_low} = phase_drive(q.cmd, q.phase + 2'd1, q.wbit);
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done_o    = q.done;
    assign rbit_o    = q.rbit;
    assign scl_low_o = q.scl_low;
    assign sda_low_o = q.sda_low;

    AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && $past(q.busy) && (q.cmd == BC_WRITE || q.cmd == BC_READ)
         && !q.scl_low && $past(!q.scl_low)) |-> $stable(q.sda_low)); // R9

endmodule

// File: rtl/hsp_conv_timer.sv
module hsp_conv_timer #(
    parameter int WAIT_CYC = 6000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    output logic expired_o
);

    localparam int CW = $clog2(WAIT_CYC + 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
        logic          fire;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d      = q;
        d.fire = 1'b0;
        if (arm_i) begin
            d.run = 1'b1;
            d.cnt = CW'(WAIT_CYC);
        end else if (q.run) begin
            if (q.cnt <= CW'(1)) begin
                d.run  = 1'b0;
                d.fire = 1'b1;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign expired_o = q.fire;

    AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.fire |=> !q.fire); // R3

endmodule

// File: rtl/hsense_poller.sv
module hsense_poller
    import hsp_pkg::*;
#(
    parameter int         CLK_HZ     = 100000000,
    parameter int         CONV_MS    = 60,
    parameter int         SCL_QTR    = 250,
    parameter logic [6:0] DEV_ADDR   = 7'h28,
    parameter logic [7:0] TRIG_BYTE  = 8'h00,
    parameter int         N_RD_BYTES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      sda_i,
    output logic                      scl_low_o,
    output logic                      sda_low_o,
    output logic [8*N_RD_BYTES-1:0]   result_o,
    output logic                      result_valid_o,
    output logic                      nack_err_o
);

    localparam int RES_W    = 8 * N_RD_BYTES;
    localparam int BCW      = $clog2(N_RD_BYTES + 1);
    localparam int WAIT_CYC = (CLK_HZ / 1000) * CONV_MS;
    localparam int WSW      = $clog2(WAIT_CYC + 1) + 1;
    localparam logic [BCW-1:0] LAST_BYTE = BCW'(N_RD_BYTES - 1);

    typedef struct packed {
        seq_state_e       st;
        logic             issued;
        logic             rd;
        logic [7:0]       tx;
        logic [2:0]       bitc;
        logic [BCW-1:0]   bytes;
        logic [RES_W-1:0] rx;
        logic [RES_W-1:0] res;
        logic             valid;
        logic             err;
    } seq_t;

    seq_t q, d;

    logic    cmd_vld;
    bitcmd_e cmd;
    logic    cmd_bit;
    logic    eng_done;
    logic    eng_rbit;
    logic    tmr_arm;
    logic    tmr_expired;
    logic    step;

    hsp_bit_engine #(.SCL_QTR(SCL_QTR)) u_bit_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid_i(cmd_vld),
        .cmd_i      (cmd),
        .cmd_bit_i  (cmd_bit),
        .sda_i      (sda_i),
        .done_o     (eng_done),
        .rbit_o     (eng_rbit),
        .scl_low_o  (scl_low_o),
        .sda_low_o  (sda_low_o)
    );

    hsp_conv_timer #(.WAIT_CYC(WAIT_CYC)) u_conv_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (tmr_arm),
        .expired_o(tmr_expired)
    );

    assign step = q.issued && eng_done;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        cmd_vld = 1'b0;
        cmd     = BC_START;
        cmd_bit = 1'b0;
        tmr_arm = 1'b0;

        if (q.st != S_IDLE && q.st != S_WAIT) begin
            cmd_vld  = !q.issued;
            d.issued = !step;
        end

        case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.err    = 1'b0;
                    d.rd     = 1'b0;
                    d.tx     = {DEV_ADDR, 1'b0};
                    d.bitc   = '0;
                    d.bytes  = '0;
                    d.issued = 1'b0;
                    d.st     = S_START;
                end
            end
            S_START: begin
                cmd = BC_START;
                if (step) d.st = S_TXBIT;
            end
            S_TXBIT: begin
                cmd     = BC_WRITE;
                cmd_bit = q.tx[7];
                if (step) begin
                    d.tx   = {q.tx[6:0], 1'b0};
                    d.bitc = q.bitc + 3'd1;
                    if (q.bitc == 3'd7) d.st = S_TXACK;
                end
            end
            S_TXACK: begin
                cmd = BC_READ;
                if (step) begin
                    d.bitc = '0;
                    if (eng_rbit) begin
                        d.err = 1'b1;
                        d.st  = S_STOP;
                    end else if (q.rd) begin
                        d.bytes = '0;
                        d.st    = S_RXBIT;
                    end else if (q.bytes == '0) begin
                        d.tx    = TRIG_BYTE;
                        d.bytes = BCW'(1);
                        d.st    = S_TXBIT;
                    end else begin
                        d.st = S_STOP;
                    end
                end
            end
            S_RXBIT: begin
                cmd = BC_READ;
                if (step) begin
                    d.rx   = {q.rx[RES_W-2:0], eng_rbit};
                    d.bitc = q.bitc + 3'd1;
                    if (q.bitc == 3'd7) d.st = S_RXACK;
                end
            end
            S_RXACK: begin
                cmd     = BC_WRITE;
                cmd_bit = (q.bytes == LAST_BYTE);
                if (step) begin
                    d.bitc = '0;
                    if (q.bytes == LAST_BYTE) begin
                        d.st = S_STOP;
                    end else begin
                        d.bytes = q.bytes + 1'b1;
                        d.st    = S_RXBIT;
                    end
                end
            end
            S_STOP: begin
                cmd = BC_STOP;
                if (step) begin
                    if (q.err) begin
                        d.st = S_IDLE;
                    end else if (!q.rd) begin
                        tmr_arm = 1'b1;
                        d.st    = S_WAIT;
                    end else begin
                        d.res   = q.rx;
                        d.valid = 1'b1;
                        d.st    = S_IDLE;
                    end
                end
            end
            S_WAIT: begin
                if (tmr_expired) begin
                    d.rd     = 1'b1;
                    d.tx     = {DEV_ADDR, 1'b1};
                    d.bitc   = '0;
                    d.bytes  = '0;
                    d.issued = 1'b0;
                    d.st     = S_START;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign result_o       = q.res;
    assign result_valid_o = q.valid;
    assign nack_err_o     = q.err;

    // Checker-only span counter for the conversion wait.
    logic [WSW-1:0] wait_span_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_span_q <= '0;
        end else if (q.st != S_WAIT) begin
            wait_span_q <= '0;
        end else begin
            wait_span_q <= wait_span_q + 1'b1;
        end
    end

    AST_WAIT_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WAIT && tmr_expired) |-> (wait_span_q >= WSW'(WAIT_CYC))); // R3
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE) |-> (!scl_low_o && !sda_low_o)); // R1
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |=> !q.valid); // R6
    AST_NO_VALID_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |-> !q.err); // R7
    AST_ERR_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE && start_i) |=> !q.err); // R8

endmodule

// File: tb/hsense_poller_bench.sv
module hsense_poller_bench;

    localparam int CLK_HZ   = 100000;
    localparam int CONV_MS  = 60;
    localparam int SCL_QTR  = 4;
    localparam int WAIT_CYC = CLK_HZ / 1000 * CONV_MS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        scl_low, sda_low;
    logic [31:0] result;
    logic        valid, err;
    logic        slv_low = 1'b0;

    wire scl = ~scl_low;
    wire sda = ~(sda_low | slv_low);

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hsense_poller #(.CLK_HZ(CLK_HZ), .CONV_MS(CONV_MS), .SCL_QTR(SCL_QTR)) u_hsense_poller (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .sda_i         (sda),
        .scl_low_o     (scl_low),
        .sda_low_o     (sda_low),
        .result_o      (result),
        .result_valid_o(valid),
        .nack_err_o    (err)
    );

    // ---------------- sensor model ----------------
    logic       nack_addr = 1'b0, nack_data = 1'b0;
    logic [7:0] rd_data [4];
    int         n_start, n_stop, n_addr, n_wr, n_mack, n_valid;
    logic [7:0] addr_log [8];
    logic [7:0] wr_log [8];
    logic [7:0] mack_bits;
    int         t_start [8];
    int         t_stop [8];
    int         mode = 0, bitc = 0, rd_idx = 0;
    logic [7:0] sh = '0;
    logic       acked = 1'b0, rw = 1'b0, last_mack = 1'b0;
    logic       scl_p = 1'b1, sda_p = 1'b1;

    always @(posedge clk) if (rst_n && valid) n_valid++;

    always @(scl or sda) begin
        if (scl_p === 1'b1 && scl === 1'b1 && sda_p === 1'b1 && sda === 1'b0) begin
            if (n_start < 8) t_start[n_start] = cyc;
            n_start++;
            mode = 1; bitc = 0; slv_low = 1'b0;
        end else if (scl_p === 1'b1 && scl === 1'b1 && sda_p === 1'b0 && sda === 1'b1) begin
            if (n_stop < 8) t_stop[n_stop] = cyc;
            n_stop++;
            mode = 0; slv_low = 1'b0;
        end else if (scl_p === 1'b0 && scl === 1'b1) begin
            if ((mode == 1 || mode == 2) && bitc < 8) sh = {sh[6:0], sda};
            if (mode == 3 && bitc == 8) begin
                last_mack = sda;
                if (n_mack < 8) mack_bits[n_mack] = sda;
                n_mack++;
            end
            bitc++;
        end else if (scl_p === 1'b1 && scl === 1'b0) begin
            if (mode == 1 || mode == 2) begin
                if (bitc == 8) begin
                    if (mode == 1) begin
                        if (n_addr < 8) addr_log[n_addr] = sh;
                        n_addr++;
                        acked = (sh[7:1] == 7'h28) && !nack_addr;
                        rw = sh[0];
                    end else begin
                        if (n_wr < 8) wr_log[n_wr] = sh;
                        n_wr++;
                        acked = !nack_data;
                    end
                    slv_low = acked;
                end else if (bitc == 9) begin
                    slv_low = 1'b0;
                    bitc = 0;
                    if (!acked) mode = 0;
                    else if (mode == 1 && rw) begin
                        mode = 3; rd_idx = 0;
                        slv_low = ~rd_data[0][7];
                    end else if (mode == 1) mode = 2;
                end
            end else if (mode == 3) begin
                if (bitc >= 1 && bitc <= 7) slv_low = ~rd_data[rd_idx][7-bitc];
                else if (bitc == 8) slv_low = 1'b0;
                else if (bitc == 9) begin
                    bitc = 0;
                    rd_idx++;
                    if (last_mack == 1'b0 && rd_idx < 4) slv_low = ~rd_data[rd_idx][7];
                    else begin mode = 0; slv_low = 1'b0; end
                end
            end
        end
        scl_p = scl;
        sda_p = sda;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        n_start = 0; n_stop = 0; n_addr = 0; n_wr = 0; n_mack = 0; n_valid = 0;
        mack_bits = '0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (valid || err) break;
        end
        repeat (60) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1", "scl drive after reset", {31'b0, scl_low}, 32'd0);
        chk("R1", "sda drive after reset", {31'b0, sda_low}, 32'd0);
        chk("R1", "valid after reset", {31'b0, valid}, 32'd0);
        chk("R1", "result after reset", result, 32'd0);
        chk("R1", "error after reset", {31'b0, err}, 32'd0);
    endtask

    task automatic t_good(input logic [31:0] pat, input bit after_err);
        rd_data[0] = pat[31:24]; rd_data[1] = pat[23:16];
        rd_data[2] = pat[15:8];  rd_data[3] = pat[7:0];
        nack_addr = 1'b0; nack_data = 1'b0;
        clear_logs();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (after_err) chk("R8", "error cleared after start", {31'b0, err}, 32'd0);
        wait_end();
        chk("R2", "write address byte", {24'b0, addr_log[0]}, 32'h50);
        chk("R2", "trigger bytes written", n_wr, 1);
        chk("R2", "trigger byte value", {24'b0, wr_log[0]}, 32'h00);
        chk("R3", "conversion gap long enough", {31'b0, (t_start[1] - t_stop[0]) >= WAIT_CYC}, 32'd1);
        chk("R4", "read address byte", {24'b0, addr_log[1]}, 32'h51);
        chk("R4", "bytes acknowledged by master", n_mack, 4);
        chk("R5", "master ack pattern", {24'b0, mack_bits}, 32'h08);
        chk("R6", "result word", result, pat);
        chk("R6", "valid cycles", n_valid, 1);
        chk("R9", "start conditions", n_start, 2);
        chk("R9", "stop conditions", n_stop, 2);
        chk("R7", "no error on clean run", {31'b0, err}, 32'd0);
        chk("R1", "lines released when idle", {30'b0, scl_low, sda_low}, 32'd0);
    endtask

    task automatic t_nack(input bit on_addr, input logic [31:0] prev);
        nack_addr = on_addr; nack_data = !on_addr;
        clear_logs();
        pulse_start();
        wait_end();
        chk("R7", "error flag set", {31'b0, err}, 32'd1);
        chk("R7", "no valid on nack", n_valid, 0);
        chk("R7", "no read transaction", n_start, 1);
        chk("R7", "stop sent", n_stop, 1);
        chk("R7", "result kept", result, prev);
        if (!on_addr) chk("R7", "trigger byte was sent", n_wr, 1);
        chk("R1", "lines released after nack", {30'b0, scl_low, sda_low}, 32'd0);
        repeat (500) @(negedge clk);
        chk("R8", "error flag held while idle", {31'b0, err}, 32'd1);
        chk("R7", "result still kept", result, prev);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_good(32'hA55A0FF0, 1'b0);
        t_good(32'h12345678, 1'b0);
        t_nack(1'b1, 32'h12345678);
        t_good(32'hFFFFFFFF, 1'b1);
        t_nack(1'b0, 32'hFFFFFFFF);
        t_good(32'h80010203, 1'b1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule